// File: doc/BRIEF.md
# Hamming Syndrome Corrector for Sector Buffers

This block checks a sector of flash data with a Hamming code and repairs a single bad bit. It takes two codes: the one computed over the sector as it was read, and the one stored next to the sector when it was written. It forms the syndrome as the XOR of the two codes and sorts the result into three classes: clean, a single-bit error it can fix, or damage it cannot fix. For a fixable error it reports the byte and the bit that went wrong.

When fixing is enabled, the block also repairs the sector buffer. It reads the bad byte through a byte-wide port, flips the bit and writes the byte back, then raises `done`. Each code holds two bits per location bit: an odd-numbered bit that carries the location bit, and an even-numbered bit that carries its complement. A single flipped data bit therefore gives a syndrome with exactly half of its bits set. `SECTOR_BYTES` sets the sector size. The code width is twice the byte-address width plus six: 22 bits for 256 bytes, 24 bits for 512 bytes, and 2 more bits for each doubling of the sector.

Top module: `hecc_corrector`

## Requirements
- R1: The syndrome is `code_calc ^ code_read`. The first code byte is in bits 7:0, the second in bits 15:8 and the third in bits 23:16. A difference anywhere in the code affects the result.
- R2: A zero syndrome gives `status` = 0 (clean), and the buffer is not written.
- R3: A syndrome with exactly CODE_W/2 ones (12 at the default size) gives `status` = 1 (fixable). This holds for any pattern with that count.
- R4: Any other nonzero syndrome gives `status` = 2 (uncorrectable). The value 3 never appears.
- R5: For a fixable result, `err_bit` holds syndrome bits 1, 3 and 5 as its bits 0, 1 and 2.
- R6: For a fixable result, `err_byte` bit i holds syndrome bit 7+2i. At the default size these are bits 7, 9, …, 23, giving byte addresses 0 to 511.
- R7: With `fix_en` high at start and a fixable result, the sequence is as follows. In the cycle after the start edge, `buf_rd_en` is high with `buf_addr` = `err_byte`. In the next cycle, `buf_wr_en` is high with `buf_wdata` = `buf_rdata` XOR (1 << `err_bit`). In the cycle after that, `done` is high.
- R8: Otherwise (clean, uncorrectable, or `fix_en` low), `done` is high in the cycle after the start edge, and the buffer is not read or written.
- R9: A start request while `busy` is high is ignored. Only one `done` pulse results, and the reported values are unchanged.
- R10: `status`, `err_byte` and `err_bit` hold until the next start is accepted. `done` is a one-cycle pulse.
- R11: After reset, `done`, `busy`, `buf_rd_en` and `buf_wr_en` are low, and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a check; sampled only when idle |
| fix_en | input | 1 | Enables the buffer repair for this check |
| code_calc | input | CODE_W (24) | Code computed over the sector data |
| code_read | input | CODE_W (24) | Code read back from the spare area |
| status | output | 2 | 0 clean, 1 fixable, 2 uncorrectable |
| err_byte | output | ADDR_W (9) | Byte address of the error |
| err_bit | output | 3 | Bit index of the error within the byte |
| done | output | 1 | One-cycle pulse when the check finishes |
| busy | output | 1 | High from the accepted start until `done` |
| buf_addr | output | ADDR_W (9) | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe; data is returned one cycle later |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Repaired byte |

## Verification
The bench builds the block with the default `SECTOR_BYTES` of 512, which gives a 24-bit code and a 9-bit byte address. This size reaches the top syndrome bit and byte address 511, along with the middle address 0x155. At this size the fixable count is 12. The bench compares it with neighbours of 1, 13 and 24 ones, and with a 12-ones pattern that does not have the complementary shape. A busy-time start and a repair with `fix_en` low show that the buffer is written only in the single repair case.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic [1:0] {
    HECC_CLEAN   = 2'd0,
    HECC_FIXABLE = 2'd1,
    HECC_FATAL   = 2'd2
  } hecc_status_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2,
    SEQ_DONE  = 2'd3
  } hecc_seq_e;

  localparam int unsigned HECC_BIT_W = 3;

endpackage

// File: rtl/hecc_rst_sync.sv
module hecc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int unsigned CODE_W = 24,
  parameter int unsigned LOC_W  = CODE_W / 2
) (
  input  logic [CODE_W-1:0] syndrome,
  output hecc_status_e      status,
  output logic [LOC_W-1:0]  loc
);

  localparam int unsigned CNT_W = $clog2(CODE_W + 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(CODE_W / 2);

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < CODE_W; i++) begin
      ones = ones + CNT_W'(syndrome[i]);
    end
  end

  // odd syndrome bits carry the location, lowest first
  for (genvar g = 0; g < LOC_W; g++) begin : g_loc
    assign loc[g] = syndrome[2*g+1];
  end

  always_comb begin
    if (syndrome == '0) begin
      status = HECC_CLEAN;
    end else if (ones == HALF) begin
      status = HECC_FIXABLE;
    end else begin
      status = HECC_FATAL;
    end
  end

endmodule

// File: rtl/hecc_seq.sv
module hecc_seq
  import hecc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic go_fix,
  output logic accept,
  output logic busy,
  output logic rd_en,
  output logic wr_en,
  output logic done
);

  hecc_seq_e state_q, state_d;

  assign accept = start && (state_q == SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          state_d = go_fix ? SEQ_READ : SEQ_DONE;
        end
      end
      SEQ_READ:  state_d = SEQ_WRITE;
      SEQ_WRITE: state_d = SEQ_DONE;
      SEQ_DONE:  state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy  = (state_q != SEQ_IDLE);
  assign rd_en = (state_q == SEQ_READ);
  assign wr_en = (state_q == SEQ_WRITE);
  assign done  = (state_q == SEQ_DONE);

endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
  import hecc_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int unsigned CODE_W       = 2 * (ADDR_W + HECC_BIT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fix_en,
  input  logic [CODE_W-1:0] code_calc,
  input  logic [CODE_W-1:0] code_read,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] err_byte,
  output logic [2:0]        err_bit,
  output logic              done,
  output logic              busy,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd_en,
  input  logic [7:0]        buf_rdata,
  output logic              buf_wr_en,
  output logic [7:0]        buf_wdata
);

  localparam int unsigned LOC_W = ADDR_W + HECC_BIT_W;

  logic              rst_int_n;
  logic [CODE_W-1:0] syndrome;
  hecc_status_e      cls_status;
  logic [LOC_W-1:0]  cls_loc;
  logic              go_fix;
  logic              accept;
  hecc_status_e      status_q;
  logic [LOC_W-1:0]  loc_q;

  hecc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign syndrome = code_calc ^ code_read;

  hecc_classify #(.CODE_W(CODE_W), .LOC_W(LOC_W)) u_cls (
    .syndrome (syndrome),
    .status   (cls_status),
    .loc      (cls_loc)
  );

  assign go_fix = fix_en && (cls_status == HECC_FIXABLE);

  hecc_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .go_fix (go_fix),
    .accept (accept),
    .busy   (busy),
    .rd_en  (buf_rd_en),
    .wr_en  (buf_wr_en),
    .done   (done)
  );

  // result registers, loaded only on an accepted start
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      status_q <= HECC_CLEAN;
      loc_q    <= '0;
    end else if (accept) begin
      status_q <= cls_status;
      loc_q    <= cls_loc;
    end
  end

  assign status    = status_q;
  assign err_bit   = loc_q[HECC_BIT_W-1:0];
  assign err_byte  = loc_q[LOC_W-1:HECC_BIT_W];
  assign buf_addr  = err_byte;
  assign buf_wdata = buf_rdata ^ (8'd1 << err_bit);

endmodule

// File: rtl/hecc_corrector_chk.sv
module hecc_corrector_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned CODE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              fix_en,
  input logic [CODE_W-1:0] code_calc,
  input logic [CODE_W-1:0] code_read,
  input logic [1:0]        status,
  input logic [ADDR_W-1:0] err_byte,
  input logic [2:0]        err_bit,
  input logic              done,
  input logic              busy,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              buf_rd_en,
  input logic [7:0]        buf_rdata,
  input logic              buf_wr_en,
  input logic [7:0]        buf_wdata
);

  assert_clean_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (code_calc == code_read)) |=> (done && status == 2'd0));

  assert_half_fixable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ($countones(code_calc ^ code_read) == CODE_W/2)) |=> (status == 2'd1));

  assert_status_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd3);

  assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> (buf_wr_en && $stable(buf_addr)));

  assert_single_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($countones(buf_wdata ^ buf_rdata) == 1));

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |=> done);

  assert_write_only_fixable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> (status == 2'd1));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

  assert_hold_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

endmodule

bind hecc_corrector hecc_corrector_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .fix_en    (fix_en),
  .code_calc (code_calc),
  .code_read (code_read),
  .status    (status),
  .err_byte  (err_byte),
  .err_bit   (err_bit),
  .done      (done),
  .busy      (busy),
  .buf_addr  (buf_addr),
  .buf_rd_en (buf_rd_en),
  .buf_rdata (buf_rdata),
  .buf_wr_en (buf_wr_en),
  .buf_wdata (buf_wdata)
);

// File: tb/hecc_corrector_test.sv
module hecc_corrector_test;

  localparam int unsigned SB = 512;
  localparam int unsigned AW = 9;
  localparam int unsigned CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          fix_en = 1'b0;
  logic [CW-1:0] code_calc = '0;
  logic [CW-1:0] code_read = '0;
  logic [1:0]    status;
  logic [AW-1:0] err_byte;
  logic [2:0]    err_bit;
  logic          done;
  logic          busy;
  logic [AW-1:0] buf_addr;
  logic          buf_rd_en;
  logic [7:0]    buf_rdata;
  logic          buf_wr_en;
  logic [7:0]    buf_wdata;

  always #2 clk = ~clk;

  hecc_corrector #(.SECTOR_BYTES(SB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fix_en(fix_en),
    .code_calc(code_calc), .code_read(code_read),
    .status(status), .err_byte(err_byte), .err_bit(err_bit),
    .done(done), .busy(busy), .buf_addr(buf_addr), .buf_rd_en(buf_rd_en),
    .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata)
  );

  // sector buffer model: synchronous read, one-cycle latency
  logic [7:0] mem [SB];
  int         writes = 0;
  always @(posedge clk) begin
    if (buf_wr_en) begin
      mem[buf_addr] <= buf_wdata;
      writes <= writes + 1;
    end
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
  end

  int    errs = 0;
  int    checks = 0;
  bit    finished = 0;

  // scoreboard queues
  int    q_st[$];
  int    q_byte[$];
  int    q_bit[$];
  int    q_mem[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] single_synd(input int b, input int k);
    logic [11:0] loc;
    logic [CW-1:0] s;
    loc = {b[8:0], k[2:0]};
    for (int i = 0; i < 12; i++) begin
      s[2*i+1] = loc[i];
      s[2*i]   = ~loc[i];
    end
    return s;
  endfunction

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_st.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        int st, eb, ek, em;
        string tg;
        st = q_st.pop_front(); eb = q_byte.pop_front(); ek = q_bit.pop_front();
        em = q_mem.pop_front(); tg = q_tag.pop_front();
        check(int'(status) == st, tg, "status", status, st);
        if (st == 1) begin
          check(int'(err_byte) == eb && int'(err_bit) == ek, tg, "location",
                {err_byte, err_bit}, (eb << 3) | ek);
        end
        check(int'(mem[eb]) == em, tg, "buffer byte", mem[eb], em);
      end
    end
  end

  task automatic run_case(input logic [CW-1:0] a, input logic [CW-1:0] synd,
                          input bit fix, input int st, input int eb, input int ek,
                          input int exp_writes, input bit poke_busy, input string tag);
    int w0;
    int orig;
    @(negedge clk);
    w0 = writes;
    orig = mem[eb];
    q_st.push_back(st); q_byte.push_back(eb); q_bit.push_back(ek);
    q_mem.push_back((st == 1 && fix) ? (orig ^ (1 << ek)) : orig);
    q_tag.push_back(tag);
    code_calc = a; code_read = a ^ synd; fix_en = fix; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      code_calc = 24'h123456; code_read = 24'h000000; fix_en = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (5) @(negedge clk);
    check(q_st.size() == 0, tag, "done seen", q_st.size(), 0);
    check(writes - w0 == exp_writes, tag, "buffer writes", writes - w0, exp_writes);
  endtask

  initial begin
    for (int i = 0; i < SB; i++) mem[i] = 8'((i * 7 + 3) & 8'hff);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!done && !busy && !buf_rd_en && !buf_wr_en && status == 2'd0,
          "R11", "reset state", {done, busy, buf_rd_en, buf_wr_en, status}, 0);

    run_case(24'h5A3C96, 24'h000000, 1, 0, 0, 0, 0, 0, "R2 clean");
    run_case(24'h0F0F0F, single_synd(0, 0), 1, 1, 0, 0, 1, 0, "R5 R6 R7 byte0 bit0");
    run_case(24'h00FF00, single_synd(511, 7), 1, 1, 511, 7, 1, 0, "R6 R7 byte511 bit7");
    run_case(24'hC3A511, single_synd(341, 2), 1, 1, 341, 2, 1, 0, "R1 R5 byte341 bit2");
    run_case(24'h777777, single_synd(300, 5), 0, 1, 300, 5, 0, 0, "R8 fix disabled");
    run_case(24'h13579B, 24'h000001, 1, 2, 0, 0, 0, 0, "R4 one bit");
    run_case(24'h2468AC, 24'hFFFFFF, 1, 2, 0, 0, 0, 0, "R4 all ones");
    run_case(24'hABCDEF, 24'h001FFF, 1, 2, 0, 0, 0, 0, "R4 thirteen ones");
    run_case(24'h000000, 24'h000FFF, 1, 1, 7, 7, 1, 0, "R3 noncanonical twelve");
    run_case(24'h800000, 24'h800000, 1, 2, 0, 0, 0, 0, "R1 top byte only");
    run_case(24'h654321, single_synd(100, 3), 1, 1, 100, 3, 1, 1, "R9 start while busy");

    // R10: values hold with no start
    repeat (4) @(negedge clk);
    check(status == 2'd1 && err_byte == 9'd100 && err_bit == 3'd3, "R10",
          "held result", {status, err_byte, err_bit}, {2'd1, 9'd100, 3'd3});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule